// File: doc/BRIEF.md
# DMA Translation Fault Capture Register

This block sits beside an address translation unit and records the first DMA translation fault that the unit reports. A fault arrives as a single-cycle strobe that carries the fault kind (segment miss or page miss), the faulting page number, the access direction and the IO ID of the requesting device. When reporting for that kind is enabled and no earlier fault is pending, the block stores the fault in a 64-bit status word, sets its valid bit and raises an interrupt.

Software reads the status word and the enable word through a small register port. It acknowledges the fault by writing the status word back with the valid bit at 0. Until then the stored fault is held. Any further enabled fault only sets a sticky overflow bit, so software can tell that faults were lost.

Top module: `xlat_fault_status`

## Requirements
- R1: After reset the status word reads 0, the enable word reads 0 and `exc_irq` is 0.
- R2: An enabled fault that arrives while the valid bit (status bit 63) is 0 is visible in the status word in the cycle after the strobe. In that word bit 63 is 1, bits 34:12 hold the page number, bit 11 holds the direction (1 = read, 0 = write) and bits 10:0 hold the IO ID.
- R3: Status bits 62:61 encode the captured fault kind. A segment fault reads as 2'b11 and a page fault reads as 2'b01. The field reads 2'b00 until the first capture.
- R4: While bit 63 is 1, an enabled fault leaves bits 62:0 other than bit 60 unchanged and sets the sticky overflow bit, status bit 60.
- R5: A write to the status word (`reg_sel`=0) clears bit 63 when `reg_wdata[63]` is 0 and clears bit 60 when `reg_wdata[60]` is 0. Writing 1 to either bit never sets it, and a write changes no other status bit.
- R6: The enable word (`reg_sel`=1) enables segment-fault reporting with bit 62 and page-fault reporting with bit 61. Every other bit of it reads 0, and a write takes effect in the next cycle.
- R7: A fault whose kind is not enabled changes neither the captured fields nor the valid bit nor the overflow bit.
- R8: `exc_irq` is 1 exactly while bit 63 is 1 and the enable bit for the captured kind is 1. It follows a change of the enable word one cycle after the write.
- R9: An enabled fault that arrives in the same cycle as a write that clears bit 63 is captured as a new fault, and it does not set bit 60.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flt_strobe | input | 1 | One-cycle fault report from the translation unit |
| flt_is_seg | input | 1 | 1 = segment fault, 0 = page fault |
| flt_page | input | 23 | Faulting page number |
| flt_read | input | 1 | 1 = read access, 0 = write access |
| flt_ioid | input | 11 | IO ID of the requesting device |
| reg_wr_en | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = status word, 1 = enable word |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Read data of the selected word (combinational) |
| exc_irq | output | 1 | Fault interrupt request |

## Verification
The hardest case to reach is a fault strobe that arrives in the same cycle as a software write that clears the valid bit. That same cycle also decides whether overflow is set or a new capture happens. The directed part of the bench builds this collision on purpose. The random part then drives fault strobes and register writes in the same cycle, with random enable words and random write data, so that collisions with both clear bits at 0 and at 1 occur many times, for both fault kinds and with reporting both enabled and disabled.

// File: rtl/xfs_pkg.sv
package xfs_pkg;

    localparam int WORD_W  = 64;
    localparam int PAGE_W  = 23;
    localparam int IOID_W  = 11;

    // Bit positions of the status and enable words
    localparam int POS_VALID = 63;
    localparam int POS_KHI   = 62;
    localparam int POS_KLO   = 61;
    localparam int POS_OVF   = 60;
    localparam int POS_PAGE  = 12;
    localparam int POS_DIR   = 11;
    localparam int POS_IOID  = 0;

    localparam int POS_EN_SEG  = 62;
    localparam int POS_EN_PAGE = 61;

    typedef enum logic {
        KIND_PAGE = 1'b0,
        KIND_SEG  = 1'b1
    } fault_kind_e;

    typedef enum logic {
        SEL_STATUS = 1'b0,
        SEL_ENABLE = 1'b1
    } reg_sel_e;

    typedef struct packed {
        fault_kind_e       kind;
        logic [PAGE_W-1:0] page;
        logic              rd;
        logic [IOID_W-1:0] ioid;
    } fault_rec_t;

    typedef struct packed {
        logic seg_en;
        logic page_en;
    } fault_enable_t;

    // Two-bit kind code: segment = 11, page = 01, nothing captured yet = 00
    function automatic logic [1:0] kind_code(input fault_kind_e k, input logic seen);
        if (!seen)
            return 2'b00;
        return (k == KIND_SEG) ? 2'b11 : 2'b01;
    endfunction

    function automatic logic [WORD_W-1:0] pack_status(
        input logic       valid,
        input logic       ovf,
        input logic       seen,
        input fault_rec_t rec
    );
        logic [WORD_W-1:0] w;
        w = '0;
        w[POS_VALID]                   = valid;
        {w[POS_KHI], w[POS_KLO]}       = kind_code(rec.kind, seen);
        w[POS_OVF]                     = ovf;
        w[POS_PAGE +: PAGE_W]          = rec.page;
        w[POS_DIR]                     = rec.rd;
        w[POS_IOID +: IOID_W]          = rec.ioid;
        return w;
    endfunction

    function automatic logic [WORD_W-1:0] pack_enable(input fault_enable_t en);
        logic [WORD_W-1:0] w;
        w = '0;
        w[POS_EN_SEG]  = en.seg_en;
        w[POS_EN_PAGE] = en.page_en;
        return w;
    endfunction

    function automatic logic kind_enabled(input fault_kind_e k, input fault_enable_t en);
        return (k == KIND_SEG) ? en.seg_en : en.page_en;
    endfunction

endpackage

// File: rtl/xfs_enable_reg.sv
module xfs_enable_reg
    import xfs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [WORD_W-1:0] wdata,
    output fault_enable_t     en_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= '0;
        end else if (wr) begin
            en_q.seg_en  <= wdata[POS_EN_SEG];
            en_q.page_en <= wdata[POS_EN_PAGE];
        end
    end
endmodule

// File: rtl/xfs_capture.sv
module xfs_capture
    import xfs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       take,      // qualified (enabled) fault this cycle
    input  fault_rec_t rec_in,
    input  logic       clr_valid, // software clears valid
    input  logic       clr_ovf,   // software clears overflow
    output logic       valid_q,
    output logic       ovf_q,
    output logic       seen_q,
    output fault_rec_t rec_q
);
    logic slot_free;
    logic capture;
    logic lost;

    // A pending fault frees its slot in the same cycle as a clearing write
    assign slot_free = !valid_q || clr_valid;
    assign capture   = take && slot_free;
    assign lost      = take && !slot_free;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            ovf_q   <= 1'b0;
            seen_q  <= 1'b0;
            rec_q   <= '0;
        end else begin
            if (capture) begin
                valid_q <= 1'b1;
                seen_q  <= 1'b1;
                rec_q   <= rec_in;
            end else if (clr_valid) begin
                valid_q <= 1'b0;
            end
            ovf_q <= (ovf_q && !clr_ovf) || lost;
        end
    end
endmodule

// File: rtl/xfs_readback.sv
module xfs_readback
    import xfs_pkg::*;
(
    input  reg_sel_e          sel,
    input  logic              valid,
    input  logic              ovf,
    input  logic              seen,
    input  fault_rec_t        rec,
    input  fault_enable_t     en,
    output logic [WORD_W-1:0] rdata
);
    always_comb begin
        unique case (sel)
            SEL_STATUS: rdata = pack_status(valid, ovf, seen, rec);
            SEL_ENABLE: rdata = pack_enable(en);
            default:    rdata = '0;
        endcase
    end
endmodule

// File: rtl/xlat_fault_status.sv
module xlat_fault_status
    import xfs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              flt_strobe,
    input  logic              flt_is_seg,
    input  logic [PAGE_W-1:0] flt_page,
    input  logic              flt_read,
    input  logic [IOID_W-1:0] flt_ioid,
    input  logic              reg_wr_en,
    input  logic              reg_sel,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    output logic              exc_irq
);
    fault_rec_t    rec_in;
    fault_rec_t    cap_rec;
    fault_enable_t en_q;
    reg_sel_e      sel;
    logic          take;
    logic          wr_status;
    logic          wr_enable;
    logic          clr_valid;
    logic          clr_ovf;
    logic          cap_valid;
    logic          cap_ovf;
    logic          cap_seen;

    assign sel         = reg_sel_e'(reg_sel);
    assign rec_in.kind = flt_is_seg ? KIND_SEG : KIND_PAGE;
    assign rec_in.page = flt_page;
    assign rec_in.rd   = flt_read;
    assign rec_in.ioid = flt_ioid;

    assign wr_status = reg_wr_en && (sel == SEL_STATUS);
    assign wr_enable = reg_wr_en && (sel == SEL_ENABLE);
    assign clr_valid = wr_status && !reg_wdata[POS_VALID];
    assign clr_ovf   = wr_status && !reg_wdata[POS_OVF];
    assign take      = flt_strobe && kind_enabled(rec_in.kind, en_q);

    xfs_enable_reg u_enable (
        .clk   (clk),
        .rst   (rst),
        .wr    (wr_enable),
        .wdata (reg_wdata),
        .en_q  (en_q)
    );

    xfs_capture u_capture (
        .clk       (clk),
        .rst       (rst),
        .take      (take),
        .rec_in    (rec_in),
        .clr_valid (clr_valid),
        .clr_ovf   (clr_ovf),
        .valid_q   (cap_valid),
        .ovf_q     (cap_ovf),
        .seen_q    (cap_seen),
        .rec_q     (cap_rec)
    );

    xfs_readback u_readback (
        .sel   (sel),
        .valid (cap_valid),
        .ovf   (cap_ovf),
        .seen  (cap_seen),
        .rec   (cap_rec),
        .en    (en_q),
        .rdata (reg_rdata)
    );

    assign exc_irq = cap_valid && kind_enabled(cap_rec.kind, en_q);

endmodule

// File: rtl/xfs_checker.sv
module xfs_checker
    import xfs_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              flt_strobe,
    input logic              flt_is_seg,
    input logic              reg_wr_en,
    input logic              reg_sel,
    input logic [WORD_W-1:0] reg_wdata,
    input logic              exc_irq,
    input logic              cap_valid,
    input logic              cap_ovf,
    input fault_rec_t        cap_rec,
    input fault_enable_t     en_q
);
    logic en_now;
    logic clr_v;
    assign en_now = flt_strobe && (flt_is_seg ? en_q.seg_en : en_q.page_en);
    assign clr_v  = reg_wr_en && !reg_sel && !reg_wdata[POS_VALID];

    AST_CAPTURE_SET: assert property (@(posedge clk) disable iff (rst)
        (en_now && !cap_valid) |=> cap_valid); // R2

    AST_FIELDS_HOLD: assert property (@(posedge clk) disable iff (rst)
        (cap_valid && !clr_v) |=> (cap_valid && $stable(cap_rec))); // R4

    AST_OVF_SET: assert property (@(posedge clk) disable iff (rst)
        (en_now && cap_valid && !clr_v) |=> cap_ovf); // R4

    AST_CLEAR_VALID: assert property (@(posedge clk) disable iff (rst)
        (clr_v && !en_now) |=> !cap_valid); // R5

    AST_MASKED_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (flt_strobe && !en_now && !cap_valid && !reg_wr_en) |=> (!cap_valid && $stable(cap_ovf))); // R7

    AST_IRQ_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
        exc_irq |-> cap_valid); // R8

    AST_COLLIDE_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        (clr_v && en_now) |=> cap_valid); // R9
endmodule

bind xlat_fault_status xfs_checker u_xfs_checker (
    .clk        (clk),
    .rst        (rst),
    .flt_strobe (flt_strobe),
    .flt_is_seg (flt_is_seg),
    .reg_wr_en  (reg_wr_en),
    .reg_sel    (reg_sel),
    .reg_wdata  (reg_wdata),
    .exc_irq    (exc_irq),
    .cap_valid  (cap_valid),
    .cap_ovf    (cap_ovf),
    .cap_rec    (cap_rec),
    .en_q       (en_q)
);

// File: tb/test_xlat_fault_status.sv
`timescale 1ns/100ps
module test_xlat_fault_status;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        flt_strobe = 1'b0;
    logic        flt_is_seg = 1'b0;
    logic [22:0] flt_page = '0;
    logic        flt_read = 1'b0;
    logic [10:0] flt_ioid = '0;
    logic        reg_wr_en = 1'b0;
    logic        reg_sel = 1'b0;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic        exc_irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // Reference state, kept from the requirements
    bit        m_v, m_ovf, m_seen, m_seg, m_rd, m_en_seg, m_en_page;
    bit [22:0] m_page;
    bit [10:0] m_ioid;

    always #2.5 clk = ~clk;

    xlat_fault_status i_xlat_fault_status (
        .clk(clk), .rst(rst), .flt_strobe(flt_strobe), .flt_is_seg(flt_is_seg),
        .flt_page(flt_page), .flt_read(flt_read), .flt_ioid(flt_ioid),
        .reg_wr_en(reg_wr_en), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .exc_irq(exc_irq)
    );

    function automatic bit [63:0] exp_status();
        bit [63:0] w = '0;
        w[63]    = m_v;
        w[62:61] = !m_seen ? 2'b00 : (m_seg ? 2'b11 : 2'b01);
        w[60]    = m_ovf;
        w[34:12] = m_page;
        w[11]    = m_rd;
        w[10:0]  = m_ioid;
        return w;
    endfunction

    function automatic bit [63:0] exp_enable();
        bit [63:0] w = '0;
        w[62] = m_en_seg;
        w[61] = m_en_page;
        return w;
    endfunction

    function automatic bit exp_irq();
        return m_v && (m_seg ? m_en_seg : m_en_page);
    endfunction

    task automatic model_step(input bit st, input bit sg, input bit [22:0] pg, input bit rd,
                              input bit [10:0] id, input bit wr, input bit sel, input bit [63:0] wd);
        bit en, cv, co;
        en = st && (sg ? m_en_seg : m_en_page);
        cv = wr && !sel && !wd[63];
        co = wr && !sel && !wd[60];
        if (en && (!m_v || cv)) begin
            m_v = 1; m_seen = 1; m_seg = sg; m_page = pg; m_rd = rd; m_ioid = id;
            m_ovf = m_ovf && !co;
        end else begin
            m_v   = m_v && !cv;
            m_ovf = (m_ovf && !co) || en;
        end
        if (wr && sel) begin
            m_en_seg  = wd[62];
            m_en_page = wd[61];
        end
    endtask

    task automatic cycle(input bit st, input bit sg, input bit [22:0] pg, input bit rd,
                         input bit [10:0] id, input bit wr, input bit sel, input bit [63:0] wd);
        @(negedge clk);
        flt_strobe = st; flt_is_seg = sg; flt_page = pg; flt_read = rd; flt_ioid = id;
        reg_wr_en = wr; reg_sel = sel; reg_wdata = wd;
        @(posedge clk);
        #1;
        flt_strobe = 0; reg_wr_en = 0;
        model_step(st, sg, pg, rd, id, wr, sel, wd);
    endtask

    task automatic check_all(input string tag);
        reg_sel = 0;
        #0.5;
        n_tests++;
        if (reg_rdata !== exp_status()) begin
            n_fail++;
            $display("FAIL %s status: actual %h expected %h", tag, reg_rdata, exp_status());
        end
        reg_sel = 1;
        #0.5;
        n_tests++;
        if (reg_rdata !== exp_enable()) begin
            n_fail++;
            $display("FAIL %s enable: actual %h expected %h", tag, reg_rdata, exp_enable());
        end
        n_tests++;
        if (exc_irq !== exp_irq()) begin
            n_fail++;
            $display("FAIL %s irq: actual %b expected %b", tag, exc_irq, exp_irq());
        end
        reg_sel = 0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (4) @(posedge clk);
        #1 rst = 0;
        check_all("R1 reset");

        // R7: fault while all reporting disabled
        cycle(1, 0, 23'h12345, 1, 11'h0AB, 0, 0, '0);
        check_all("R7 masked page fault");

        // R6: enable word, only two bits kept
        cycle(0, 0, '0, 0, '0, 1, 1, 64'hFFFF_FFFF_FFFF_FFFF);
        check_all("R6 enable all ones");
        cycle(0, 0, '0, 0, '0, 1, 1, 64'h2000_0000_0000_0000);
        check_all("R6 page only");

        // R2 R3: page fault captured
        cycle(1, 0, 23'h6ABCDE, 1, 11'h5A5, 0, 0, '0);
        check_all("R2 R3 page capture");

        // R7: segment fault disabled while valid: no overflow
        cycle(1, 1, 23'h1, 0, 11'h1, 0, 0, '0);
        check_all("R7 masked while valid");

        // R4: enabled page fault while valid sets overflow, fields hold
        cycle(1, 0, 23'h7FFFFF, 0, 11'h7FF, 0, 0, '0);
        check_all("R4 overflow");

        // R5: writing ones changes nothing
        cycle(0, 0, '0, 0, '0, 1, 0, 64'hFFFF_FFFF_FFFF_FFFF);
        check_all("R5 write ones");
        // R5: clear overflow only
        cycle(0, 0, '0, 0, '0, 1, 0, 64'h8000_0000_0000_0000);
        check_all("R5 clear overflow");
        // R5: clear valid
        cycle(0, 0, '0, 0, '0, 1, 0, 64'h0);
        check_all("R5 clear valid");

        // R3 R8: segment fault, then disable segments
        cycle(0, 0, '0, 0, '0, 1, 1, 64'h6000_0000_0000_0000);
        cycle(1, 1, 23'h00F0F0, 0, 11'h321, 0, 0, '0);
        check_all("R3 R8 segment capture");
        cycle(0, 0, '0, 0, '0, 1, 1, 64'h2000_0000_0000_0000);
        check_all("R8 irq follows enable");

        // R9: clearing write collides with enabled fault
        cycle(1, 0, 23'h0BEEF, 1, 11'h042, 1, 0, 64'h1000_0000_0000_0000);
        check_all("R9 collision capture");

        // Random mix
        for (int i = 0; i < 400; i++) begin
            bit st, sg, rd, wr, sel;
            bit [22:0] pg;
            bit [10:0] id;
            bit [63:0] wd;
            st  = ($urandom % 3) != 0;
            sg  = $urandom;
            rd  = $urandom;
            pg  = $urandom;
            id  = $urandom;
            wr  = ($urandom % 2) == 0;
            sel = ($urandom % 4) == 0;
            wd  = {$urandom, $urandom};
            cycle(st, sg, pg, rd, id, wr, sel, wd);
            check_all("R2 R4 R5 R7 R8 R9 random");
        end

        finish_run();
    end
endmodule